// File: doc/BRIEF.md
# Paged MDIO 32-bit Register Bridge

This block lets a host read and write 32-bit registers inside a managed switch whose only management path is a 16-bit clause-22 MDIO bus. The switch reaches its wide register space through a page-select register and an indirect data window. The bridge breaks each host register address into three parts: a page number, a window sub-address and a base register offset. For each access it writes the page, waits a fixed settling time, and then moves the two 16-bit halves through the window.

The host side is a single-request interface. When `req_valid` is seen while the bridge is idle, the request is captured and `busy` goes high. `busy` stays high until the third and last MDIO frame has finished. In the same cycle that `busy` falls, `done` pulses for one cycle. A read result sits on `rd_data` from that cycle on. The MDIO side is a clock divider that makes MDC, plus a frame engine that drives MDIO and releases the line to the switch during the read turnaround and read data.

Top module: `pgmdio_bridge`

## Requirements
- R1: The register address `req_addr[17:0]` splits as follows. The page is `req_addr[17:9]`. The window PHY address is `5'h10 | req_addr[8:6]`. The base register is `{req_addr[5:2], 1'b0}`. Bits `req_addr[1:0]` have no effect on any frame or on the result.
- R2: Every access begins with a write frame to PHY address `5'h18`, register 0. Its 16-bit data is the page, zero-extended.
- R3: After the page frame ends, MDC stays quiet for at least `SETTLE_CYC` system cycles before the next frame begins.
- R4: A read fetches the low half from the base register and then the high half from base+1. When `done` pulses, `rd_data` equals `{high, low}`.
- R5: A write sends `req_wdata[31:16]` to base+1 first, then `req_wdata[15:0]` to the base register.
- R6: Each access produces exactly three frames, each laid out in this order:
  - 32 preamble ones;
  - the start pattern `01`;
  - the opcode, `01` for write and `10` for read;
  - the 5-bit PHY address, MSB first;
  - the 5-bit register address, MSB first;
  - a turnaround, driven as `10` on writes;
  - 16 data bits, MSB first.
- R7: MDC stays low while no frame is running. During a frame, each MDC high phase lasts exactly `MDC_HALF` system cycles and each whole bit lasts `2*MDC_HALF` cycles.
- R8: `mdio_oe` is low whenever the bridge is idle. In a read frame it is also low through the turnaround and the data bits. At every other bit of a frame it is high.
- R9: `busy` rises in the cycle after a request is accepted and stays high until the access completes. `done` is a single-cycle pulse in the cycle where `busy` falls.
- R10: A request presented while `busy` is high is ignored. It produces no frames and does not alter the access in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address of the 32-bit register |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value as seen by the bridge |

## Verification
A wrong step counter or wrong half selection in the sequencer shows up at the very next frame. That frame carries the wrong PHY or register field, or the halves arrive in the wrong order, so the error is visible within one 64-bit frame of the fault. A corrupted settle counter shows as a shortened quiet gap on MDC before the second frame. A stuck frame-engine state shows as a wrong frame count at the moment `done` pulses, or as `mdio_oe` still driven while the switch owns the line, within a few bit times. A bridge that wrongly accepts a request while busy starts a fourth frame or re-captures the address, and the next data frame exposes it.

// File: rtl/pgmdio_pkg.sv
package pgmdio_pkg;
    localparam int PAGE_W     = 9;
    localparam int SUB_W      = 3;
    localparam int OFF_W      = 4;
    localparam int ADDR_W     = 2 + OFF_W + SUB_W + PAGE_W;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = DATA_W / 2;
    localparam int MDIO_AW    = 5;
    localparam int FRAME_BITS = 64;
    localparam int TA_BIT     = 46;
    localparam int DATA_BIT   = 48;

    localparam logic [MDIO_AW-1:0] PAGE_PHY = 5'h18;
    localparam logic [MDIO_AW-1:0] WIN_PHY  = 5'h10;

    typedef struct packed {
        logic [PAGE_W-1:0]  page;
        logic [SUB_W-1:0]   sub;
        logic [MDIO_AW-1:0] base;
    } addr_split_t;

    function automatic addr_split_t split_addr(input logic [ADDR_W-1:0] a);
        addr_split_t s;
        s.page = a[ADDR_W-1 -: PAGE_W];
        s.sub  = a[2+OFF_W +: SUB_W];
        s.base = {a[2 +: OFF_W], 1'b0};
        return s;
    endfunction
endpackage

// File: rtl/pgmdio_frame_eng.sv
module pgmdio_frame_eng
    import pgmdio_pkg::*;
#(
    parameter int MDC_HALF = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rd,
    input  logic [MDIO_AW-1:0] phy,
    input  logic [MDIO_AW-1:0] regad,
    input  logic [HALF_W-1:0]  wdata,
    output logic               ready,
    output logic               done,
    output logic [HALF_W-1:0]  rdata,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    localparam int CNT_W = (2 * MDC_HALF > 1) ? $clog2(2 * MDC_HALF) : 1;
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] HALF_V = CNT_W'(MDC_HALF);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(2 * MDC_HALF - 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TA  = IDX_W'(TA_BIT);
    localparam logic [IDX_W-1:0] IDX_DAT = IDX_W'(DATA_BIT);

    typedef struct packed {
        logic                  run;
        logic                  rd;
        logic                  done;
        logic [CNT_W-1:0]      cnt;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] word;
        logic [HALF_W-1:0]     rsh;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.run) begin
            if (start) begin
                d.run  = 1'b1;
                d.rd   = rd;
                d.cnt  = '0;
                d.idx  = '0;
                d.rsh  = '0;
                d.word = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
                          2'b10, (rd ? {HALF_W{1'b0}} : wdata)};
            end
        end else begin
            if (q.cnt == HALF_V && q.rd && q.idx >= IDX_DAT) begin
                d.rsh = {q.rsh[HALF_W-2:0], mdio_i};
            end
            if (q.cnt == LAST_V) begin
                d.cnt = '0;
                if (q.idx == IDX_END) begin
                    d.run  = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.idx  = q.idx + 1'b1;
                    d.word = {q.word[FRAME_BITS-2:0], 1'b1};
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready   = !q.run;
    assign done    = q.done;
    assign rdata   = q.rsh;
    assign mdc     = q.run && (q.cnt >= HALF_V);
    assign mdio_o  = q.word[FRAME_BITS-1];
    assign mdio_oe = q.run && !(q.rd && q.idx >= IDX_TA);
endmodule

// File: rtl/pgmdio_seq.sv
module pgmdio_seq
    import pgmdio_pkg::*;
#(
    parameter int SETTLE_CYC = 150000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               eng_start,
    output logic               eng_rd,
    output logic [MDIO_AW-1:0] eng_phy,
    output logic [MDIO_AW-1:0] eng_reg,
    output logic [HALF_W-1:0]  eng_wdata,
    input  logic               eng_done,
    input  logic [HALF_W-1:0]  eng_rdata
);
    localparam int SCNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [SCNT_W-1:0] SETTLE_LAST = SCNT_W'(SETTLE_CYC - 1);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_SETTLE} st_e;

    typedef struct packed {
        st_e               st;
        logic [1:0]        step;
        logic              wr;
        addr_split_t       ad;
        logic [DATA_W-1:0] wdata;
        logic [HALF_W-1:0] lo;
        logic [DATA_W-1:0] rdata;
        logic [SCNT_W-1:0] scnt;
        logic              busy;
        logic              done;
    } seq_t;

    seq_t q, d;

    // frame parameters chosen by the current step
    always_comb begin
        eng_rd    = 1'b0;
        eng_phy   = WIN_PHY | MDIO_AW'(q.ad.sub);
        eng_reg   = q.ad.base;
        eng_wdata = q.wdata[HALF_W-1:0];
        unique case (q.step)
            2'd0: begin
                eng_phy   = PAGE_PHY;
                eng_reg   = '0;
                eng_wdata = HALF_W'(q.ad.page);
            end
            2'd1: begin
                if (q.wr) begin
                    eng_reg   = q.ad.base | 5'd1;
                    eng_wdata = q.wdata[DATA_W-1:HALF_W];
                end else begin
                    eng_rd = 1'b1;
                end
            end
            default: begin
                if (!q.wr) begin
                    eng_rd  = 1'b1;
                    eng_reg = q.ad.base | 5'd1;
                end
            end
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.st    = S_ISSUE;
                    d.step  = 2'd0;
                    d.wr    = req_write;
                    d.ad    = split_addr(req_addr);
                    d.wdata = req_wdata;
                    d.busy  = 1'b1;
                end
            end
            S_ISSUE: d.st = S_WAIT;
            S_WAIT: begin
                if (eng_done) begin
                    unique case (q.step)
                        2'd0: begin
                            d.st   = S_SETTLE;
                            d.scnt = '0;
                        end
                        2'd1: begin
                            d.lo   = eng_rdata;
                            d.step = 2'd2;
                            d.st   = S_ISSUE;
                        end
                        default: begin
                            d.st   = S_IDLE;
                            d.busy = 1'b0;
                            d.done = 1'b1;
                            if (!q.wr) d.rdata = {eng_rdata, q.lo};
                        end
                    endcase
                end
            end
            default: begin
                if (q.scnt == SETTLE_LAST) begin
                    d.st   = S_ISSUE;
                    d.step = 2'd1;
                end else begin
                    d.scnt = q.scnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign eng_start = (q.st == S_ISSUE);
    assign busy      = q.busy;
    assign done      = q.done;
    assign rd_data   = q.rdata;
endmodule

// File: rtl/pgmdio_bridge.sv
module pgmdio_bridge
    import pgmdio_pkg::*;
#(
    parameter int MDC_HALF   = 20,
    parameter int SETTLE_CYC = 150000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic               eng_start, eng_rd, eng_done, eng_ready;
    logic [MDIO_AW-1:0] eng_phy, eng_reg;
    logic [HALF_W-1:0]  eng_wdata, eng_rdata;

    pgmdio_seq #(.SETTLE_CYC(SETTLE_CYC)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .eng_start (eng_start),
        .eng_rd    (eng_rd),
        .eng_phy   (eng_phy),
        .eng_reg   (eng_reg),
        .eng_wdata (eng_wdata),
        .eng_done  (eng_done),
        .eng_rdata (eng_rdata)
    );

    pgmdio_frame_eng #(.MDC_HALF(MDC_HALF)) eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start && eng_ready),
        .rd      (eng_rd),
        .phy     (eng_phy),
        .regad   (eng_reg),
        .wdata   (eng_wdata),
        .ready   (eng_ready),
        .done    (eng_done),
        .rdata   (eng_rdata),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .mdio_i  (mdio_i)
    );
endmodule

// File: rtl/pgmdio_bridge_chk.sv
module pgmdio_bridge_chk #(
    parameter int MDC_HALF = 20
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_oe
);
    logic        mdc_prev;
    logic [15:0] phase_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev  <= 1'b0;
            phase_cnt <= '0;
        end else begin
            mdc_prev <= mdc;
            if (mdc != mdc_prev) phase_cnt <= '0;
            else if (phase_cnt != 16'hFFFF) phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R7
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R7
    mdc_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_prev && !mdc) |-> (phase_cnt == 16'(MDC_HALF - 1)));
    // R8
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

bind pgmdio_bridge pgmdio_bridge_chk #(.MDC_HALF(MDC_HALF)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe)
);

// File: tb/pgmdio_bridge_tb_top.sv
module pgmdio_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF   = 2;
    localparam int SETTLE = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
    logic [31:0] rd_data;

    pgmdio_bridge #(.MDC_HALF(HALF), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- switch-side MDIO model ----------------
    logic [15:0] seed = '0;
    logic        slave_drv = 1'b1;
    assign mdio_i = mdio_oe ? mdio_o : slave_drv;

    function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r,
                                         input logic [15:0] s);
        return (16'(p) * 16'h0347) ^ (16'(r) * 16'h1F3B) ^ s;
    endfunction

    int          pos = 0, ones = 0, n_tr = 0;
    bit          fmt_err = 0, oe_err = 0;
    logic [1:0]  op;
    logic [4:0]  phy, rg;
    logic [15:0] sh, rsp;
    int          first_cur;
    logic [1:0]  t_op   [8];
    logic [4:0]  t_phy  [8];
    logic [4:0]  t_reg  [8];
    logic [15:0] t_data [8];
    int          t_first[8];
    int          t_end  [8];

    always @(posedge mdc) begin
        if (pos == 0) begin
            if (ones == 0) first_cur = cyc;
            if (!mdio_oe) oe_err = 1;
            if (mdio_i) ones++;
            else begin
                if (ones < 32) fmt_err = 1;
                pos = 1;
            end
        end else begin
            if (pos >= 14 && op == 2'b10) begin
                if (mdio_oe) oe_err = 1;
            end else if (!mdio_oe) oe_err = 1;
            if (pos == 1 && !mdio_i) fmt_err = 1;
            if (pos >= 2 && pos <= 3) op = {op[0], mdio_i};
            if (pos >= 4 && pos <= 8) phy = {phy[3:0], mdio_i};
            if (pos >= 9 && pos <= 13) rg = {rg[3:0], mdio_i};
            if (pos == 14) begin
                if (op != 2'b01 && op != 2'b10) fmt_err = 1;
                if (op == 2'b01 && !mdio_i) fmt_err = 1;
                rsp = resp(phy, rg, seed);
            end
            if (pos == 15 && op == 2'b01 && mdio_i) fmt_err = 1;
            if (pos >= 16) sh = {sh[14:0], mdio_i};
            if (pos == 31) begin
                if (n_tr < 8) begin
                    t_op[n_tr] = op; t_phy[n_tr] = phy; t_reg[n_tr] = rg;
                    t_data[n_tr] = sh; t_first[n_tr] = first_cur; t_end[n_tr] = cyc;
                end
                n_tr++;
                pos = 0;
                ones = 0;
            end else pos++;
        end
    end

    always @(negedge mdc) begin
        if (pos >= 16 && pos <= 31 && op == 2'b10) slave_drv = rsp[31-pos];
        else slave_drv = 1'b1;
    end

    // ---------------- one access with expected-value checks ----------------
    task automatic access(input bit wr, input logic [17:0] a, input logic [31:0] wd,
                          input logic [15:0] sd);
        logic [8:0]  pg;
        logic [4:0]  win, base;
        int          w;
        seed = sd; n_tr = 0; fmt_err = 0; oe_err = 0;
        pg   = a[17:9];
        win  = 5'h10 | {2'b00, a[8:6]};
        base = {a[5:2], 1'b0};
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
        // R10: a competing request while busy
        req_write = !wr; req_addr = ~a; req_wdata = ~wd;
        repeat (5) @(negedge clk);
        req_valid = 0;
        w = 0;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        chk(done == 1'b1, "R9 done pulse", 32'(done), 32'd1);
        chk(busy == 1'b0, "R9 busy low at done", 32'(busy), 32'd0);
        chk(n_tr == 3, "R6 frame count", 32'(n_tr), 32'd3);
        chk(!fmt_err, "R6 frame format", 32'(fmt_err), 32'd0);
        chk(!oe_err, "R8 output enable", 32'(oe_err), 32'd0);
        chk(t_op[0] == 2'b01 && t_phy[0] == 5'h18 && t_reg[0] == 5'd0,
            "R2 page frame header", {22'd0, t_op[0], t_phy[0], t_reg[0]},
            {22'd0, 2'b01, 5'h18, 5'd0});
        chk(t_data[0] == {7'd0, pg}, "R2 page data", 32'(t_data[0]), 32'(pg));
        chk(t_first[1] - t_end[0] >= SETTLE, "R3 settle gap",
            32'(t_first[1] - t_end[0]), 32'(SETTLE));
        chk(t_end[1] - t_first[1] == 63 * 2 * HALF, "R7 frame length",
            32'(t_end[1] - t_first[1]), 32'(63 * 2 * HALF));
        chk(t_phy[1] == win && t_phy[2] == win, "R1 window phy",
            {t_phy[1], t_phy[2]}, {win, win});
        if (wr) begin
            chk(t_op[1] == 2'b01 && t_op[2] == 2'b01, "R5 write opcodes",
                {t_op[1], t_op[2]}, 32'b0101);
            chk(t_reg[1] == (base | 5'd1) && t_data[1] == wd[31:16], "R5 high half first",
                {t_reg[1], t_data[1]}, {base | 5'd1, wd[31:16]});
            chk(t_reg[2] == base && t_data[2] == wd[15:0], "R5 low half second",
                {t_reg[2], t_data[2]}, {base, wd[15:0]});
        end else begin
            chk(t_op[1] == 2'b10 && t_op[2] == 2'b10, "R4 read opcodes",
                {t_op[1], t_op[2]}, 32'b1010);
            chk(t_reg[1] == base && t_reg[2] == (base | 5'd1), "R4 half order",
                {t_reg[1], t_reg[2]}, {base, base | 5'd1});
            chk(rd_data == {resp(win, base | 5'd1, sd), resp(win, base, sd)},
                "R4 R1 read result", rd_data,
                {resp(win, base | 5'd1, sd), resp(win, base, sd)});
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'd0);
        repeat (20) @(negedge clk);
        chk(n_tr == 3 && !busy, "R10 busy request ignored", 32'(n_tr), 32'd3);
    endtask

    bit finished = 0;

    initial begin
        logic [17:0] a;
        logic [31:0] wd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R9 reset state", {busy, done}, 32'd0);
        chk(!mdc && !mdio_oe, "R7 R8 reset lines", {mdc, mdio_oe}, 32'd0);
        for (int i = 0; i < 42; i++) begin
            if (i == 0) a = '0;
            else if (i == 1) a = 18'h3FFFF;
            else a = 18'(i * 18'h0B6D3 + 18'h01234);
            wd = 32'(i) * 32'h0123_4567 ^ 32'hA5A5_5A5A;
            access(1'b1, a, wd, 16'(i * 16'h9E37));
            access(1'b0, a, 32'd0, 16'(i * 16'h9E37 + 16'h0101));
        end
        // R1: low address bits have no effect
        access(1'b0, 18'h2A5C0 | 18'h3, 32'd0, 16'h4321);
        access(1'b0, 18'h2A5C0, 32'd0, 16'h4321);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule